// File: doc/BRIEF.md
# Asynchronous Serial Receiver

This block turns a start-stop framed serial line back into characters. It runs from its own local clock, and no clock travels with the data. The line rests high. A character begins when the line drops low. The input first passes through a synchronizer. A prescaler then produces a tick at sixteen times the bit rate, and the block samples each bit at its centre. Because sampling is centred, the sender's bit rate may differ from the receiver's by a few percent and every bit is still read inside its own period.

The frame settings are taken at run time and must match the sender: 5 to 8 data bits, parity (none, even or odd) and one or two stop bits. Each character appears on `rx_data` with a one-cycle `rx_valid` strobe. A parity-error flag and a framing-error flag are reported with the strobe.

The control is a six-state machine:
- **IDLE** goes to **START** when the synchronized line is low.
- **START** checks the line at its half-bit point. It returns to **IDLE** if the line is high there (a glitch) and goes to **DATA** if it is still low.
- **DATA** reads one bit per bit time. After the last data bit it goes to **PARITY** if parity is on, or to **STOP** if it is off.
- **PARITY** goes to **STOP** after one bit time.
- **STOP** reads one stop bit, or two. It then goes to **IDLE**, or to **REARM** if any stop sample was low.
- **REARM** goes to **IDLE** once the line is high again.

Top module: `srx_top`

## Requirements
- R1: After reset `rx_valid`, `rx_data`, `par_err` and `frm_err` are all 0.
- R2: Data bits arrive least significant first. The `cfg_len` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. The character is right-aligned in `rx_data` with the unused upper bits 0. `rx_valid` is high for exactly one clock per character.
- R3: A low pulse shorter than half a bit time is not taken as a start bit. It produces no character, and the next proper frame is received correctly.
- R4: With `cfg_par` = 01 (even), one parity bit follows the data. `par_err` is 1 with the strobe when the data bits plus the parity bit hold an odd number of ones, and 0 otherwise.
- R5: With `cfg_par` = 10 (odd), `par_err` is 1 when the data bits plus the parity bit hold an even number of ones. With `cfg_par` = 00 or 11, no parity bit is expected and `par_err` is 0.
- R6: A low level at the stop-bit sample sets `frm_err` with the strobe. The data bits are still delivered.
- R7: With `cfg_stop2` = 1, both stop bits are sampled, and a low level at either one sets `frm_err`. With `cfg_stop2` = 0, only one stop bit is sampled.
- R8: After a frame with a framing error, a line that stays low produces no new character until the line has been high again.
- R9: An 8-data-bit frame is received correctly when the sender's bit period is about 5 percent shorter or longer than the receiver's nominal bit period.
- R10: `par_err` and `frm_err` keep their values from one strobe until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local receiver clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_in | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Data length code: 5 + value bits |
| cfg_par | input | 2 | Parity: 00 none, 01 even, 10 odd, 11 none |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| rx_data | output | 8 | Received character, right-aligned |
| rx_valid | output | 1 | One-cycle strobe per character |
| par_err | output | 1 | Parity mismatch for the last character |
| frm_err | output | 1 | Low stop sample in the last character |

## Verification
Clean frames are sent at each of the four data lengths. These show that bits are assembled least significant first and that the unused upper bits are masked. Even and odd parity frames are sent both with a correct parity bit and with a flipped one, and parity code 11 is also tried. Together these separate the check polarity from the case where no parity bit is expected.

Frames with a low first stop bit, and frames with a low second stop bit, separate single-stop from double-stop framing. One bad frame is followed by a long low hold, which shows that the receiver waits for the line to go high before it accepts another start bit. A short low glitch, and frames sent at bit periods 61 and 67 clocks against a nominal 64, check start validation and tolerance to a rate mismatch.

// File: rtl/srx_pkg.sv
package srx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_REARM
    } rx_state_t;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_OFF  = 2'b11
    } par_mode_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] ff;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff[i] <= 1'b1;
                else        ff[i] <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ff[i] <= 1'b1;
                else        ff[i] <= ff[i-1];
            end
        end
    end

    assign d_out = ff[STAGES-1];
endmodule

// File: rtl/srx_tick.sv
module srx_tick #(
    parameter int DIV = 27
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (clr)         cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    // Ticks are spaced apart, which sets the bit-time grid used for R9.
    assert_tick_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/srx_top.sv
module srx_top #(
    parameter int CLKS_PER_TICK = 27,
    parameter int OSR           = 16,
    parameter int DW            = 8,
    parameter int SYNC_STAGES   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_in,
    input  logic [1:0]    cfg_len,
    input  logic [1:0]    cfg_par,
    input  logic          cfg_stop2,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid,
    output logic          par_err,
    output logic          frm_err
);
    import srx_pkg::*;

    localparam int CW = $clog2(OSR);
    localparam int IW = $clog2(DW);
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] FULL = CW'(OSR - 1);
    localparam logic [IW:0]   DWL  = (IW + 1)'(DW);

    rx_state_t state, nxt;
    logic          rxs, tick;
    logic [CW-1:0] cnt;
    logic [IW-1:0] bidx;
    logic          sidx;
    logic [DW-1:0] sh;
    logic          pe_r, fe_r;
    logic [IW:0]   nbits;
    logic [IW-1:0] lastidx;
    logic          mid_pt, full_pt, par_on, last_stop, done;
    par_mode_t     pmode;

    srx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(rx_in), .d_out(rxs)
    );

    srx_tick #(.DIV(CLKS_PER_TICK)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(state == ST_IDLE), .tick(tick)
    );

    assign pmode     = par_mode_t'(cfg_par);
    assign par_on    = (pmode == PAR_EVEN) || (pmode == PAR_ODD);
    assign nbits     = (IW + 1)'(cfg_len) + (IW + 1)'(5);
    assign lastidx   = IW'(nbits - 1'b1);
    assign mid_pt    = tick && (cnt == MID);
    assign full_pt   = tick && (cnt == FULL);
    assign last_stop = sidx || !cfg_stop2;
    assign done      = (state == ST_STOP) && full_pt && last_stop;

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (!rxs) nxt = ST_START;
            ST_START:  if (mid_pt) nxt = rxs ? ST_IDLE : ST_DATA;
            ST_DATA:   if (full_pt && bidx == lastidx) nxt = par_on ? ST_PARITY : ST_STOP;
            ST_PARITY: if (full_pt) nxt = ST_STOP;
            ST_STOP:   if (full_pt && last_stop) nxt = (fe_r || !rxs) ? ST_REARM : ST_IDLE;
            ST_REARM:  if (rxs) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // State register and bit-timing datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            bidx  <= '0;
            sidx  <= 1'b0;
            sh    <= '0;
            pe_r  <= 1'b0;
            fe_r  <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE || mid_pt && state == ST_START || full_pt) cnt <= '0;
            else if (tick) cnt <= cnt + 1'b1;
            if (state == ST_IDLE) begin
                bidx <= '0;
                sidx <= 1'b0;
                sh   <= '0;
                pe_r <= 1'b0;
                fe_r <= 1'b0;
            end else if (full_pt) begin
                unique case (state)
                    ST_DATA: begin
                        sh   <= {rxs, sh[DW-1:1]};
                        bidx <= bidx + 1'b1;
                    end
                    ST_PARITY: pe_r <= rxs ^ (^sh) ^ (pmode == PAR_ODD);
                    ST_STOP: begin
                        sidx <= 1'b1;
                        if (!rxs) fe_r <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            rx_data  <= '0;
            par_err  <= 1'b0;
            frm_err  <= 1'b0;
        end else begin
            rx_valid <= done;
            if (done) begin
                rx_data <= sh >> (DWL - nbits);
                par_err <= pe_r;
                frm_err <= fe_r || !rxs;
            end
        end
    end

    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_glitch_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && mid_pt && rxs) |=> (state == ST_IDLE && !rx_valid));

    assert_no_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !par_on) |-> !par_err);

    assert_rearm_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REARM && !rxs) |=> (state == ST_REARM && !rx_valid));

    assert_flags_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(par_err) && $stable(frm_err)));
endmodule

// File: tb/sim_srx_top.sv
module sim_srx_top;
    localparam int DIV = 4;
    localparam int BIT = DIV * 16;

    typedef struct packed {
        logic [7:0] d;
        logic       pe;
        logic       fe;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_in = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic [1:0] cfg_par = 2'd0;
    logic       cfg_stop2 = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid, par_err, frm_err;

    exp_t  q[$];
    string tq[$];
    string cur_tag = "R1";
    int    checks = 0;
    int    fails = 0;
    bit    finished = 0;

    srx_top #(.CLKS_PER_TICK(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .cfg_len(cfg_len),
        .cfg_par(cfg_par), .cfg_stop2(cfg_stop2), .rx_data(rx_data),
        .rx_valid(rx_valid), .par_err(par_err), .frm_err(frm_err)
    );

    always #10 clk = ~clk;

    // Monitor: pop the expected item when a character is strobed
    always @(negedge clk) begin
        exp_t  e;
        string t;
        if (rst_n && rx_valid) begin
            checks++;
            if (q.size() == 0) begin
                fails++;
                $display("FAIL %s unexpected char data=%h pe=%b fe=%b expected none",
                         cur_tag, rx_data, par_err, frm_err);
            end else begin
                e = q.pop_front();
                t = tq.pop_front();
                if (rx_data !== e.d || par_err !== e.pe || frm_err !== e.fe) begin
                    fails++;
                    $display("FAIL %s data=%h pe=%b fe=%b expected data=%h pe=%b fe=%b",
                             t, rx_data, par_err, frm_err, e.d, e.pe, e.fe);
                end
            end
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic line(input logic v, input int cycles);
        rx_in = v;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic send(input string tag, input logic [7:0] d, input int lc, input int pm,
                        input bit flip, input bit two, input bit bad1, input bit bad2,
                        input int per, input int low_after);
        int         n;
        logic [7:0] m;
        logic       p;
        exp_t       e;
        n = 5 + lc;
        m = d & 8'((1 << n) - 1);
        cfg_len = 2'(lc);
        cfg_par = 2'(pm);
        cfg_stop2 = two;
        cur_tag = tag;
        e.d  = m;
        e.pe = flip && (pm == 1 || pm == 2);
        e.fe = bad1 || (two && bad2);
        q.push_back(e);
        tq.push_back(tag);
        line(1'b0, per);
        for (int i = 0; i < n; i++) line(m[i], per);
        p = (pm == 2) ? ~(^m) : (^m);
        if (pm == 1 || pm == 2) line(p ^ flip, per);
        line(!bad1, per);
        if (two) line(!bad2, per);
        if (low_after > 0) line(1'b0, low_after * per);
        line(1'b1, 2 * BIT);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired, run incomplete");
            finish_run();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rx_valid !== 1'b0 || rx_data !== 8'h00 || par_err !== 1'b0 || frm_err !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset outputs v=%b d=%h pe=%b fe=%b expected 0 00 0 0",
                     rx_valid, rx_data, par_err, frm_err);
        end
        line(1'b1, 2 * BIT);
        // R2: lengths and bit order
        send("R2", 8'hA5, 3, 0, 0, 0, 0, 0, BIT, 0);
        send("R2", 8'hF3, 0, 0, 0, 0, 0, 0, BIT, 0);
        send("R2", 8'hEA, 1, 0, 0, 0, 0, 0, BIT, 0);
        send("R2", 8'h4D, 2, 0, 0, 0, 0, 0, BIT, 0);
        // R4: even parity
        send("R4", 8'h3C, 3, 1, 0, 0, 0, 0, BIT, 0);
        send("R4", 8'h3D, 3, 1, 1, 0, 0, 0, BIT, 0);
        // R5: odd parity and disabled parity
        send("R5", 8'h81, 3, 2, 0, 0, 0, 0, BIT, 0);
        send("R5", 8'h17, 2, 2, 1, 0, 0, 0, BIT, 0);
        send("R5", 8'h5A, 3, 3, 1, 0, 0, 0, BIT, 0);
        // R6: low stop bit
        send("R6", 8'h66, 3, 0, 0, 0, 1, 0, BIT, 0);
        // R7: two stop bits, good and bad second stop
        send("R7", 8'h99, 3, 1, 0, 1, 0, 0, BIT, 0);
        send("R7", 8'h12, 1, 0, 0, 1, 0, 1, BIT, 0);
        // R3: short glitch, then a proper frame
        cur_tag = "R3";
        line(1'b0, BIT / 4);
        line(1'b1, 2 * BIT);
        send("R3", 8'hC3, 3, 0, 0, 0, 0, 0, BIT, 0);
        // R8: bad stop followed by a long low hold
        send("R8", 8'h0F, 3, 0, 0, 0, 1, 0, BIT, 4);
        send("R8", 8'h71, 3, 0, 0, 0, 0, 0, BIT, 0);
        // R9: rate mismatch
        send("R9", 8'hB6, 3, 0, 0, 0, 0, 0, 61, 0);
        send("R9", 8'h6B, 3, 0, 0, 0, 0, 0, 67, 0);
        // R10: flags hold until the next strobe
        send("R10", 8'h24, 3, 1, 1, 0, 1, 0, BIT, 0);
        cur_tag = "R10";
        line(1'b1, 3 * BIT);
        checks++;
        if (par_err !== 1'b1 || frm_err !== 1'b1) begin
            fails++;
            $display("FAIL R10 held flags pe=%b fe=%b expected 1 1", par_err, frm_err);
        end
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R2 missing chars count=%0d expected 0", q.size());
        end
        finished = 1;
        finish_run();
    end
endmodule